// File: doc/BRIEF.md
# FLL Lock Status Tracker

This block keeps track of whether a frequency-locked loop in a clock generator is locked, and keeps a record of lock losses that nobody asked for. A lock comparator outside the block supplies a raw lock indication. The block filters it into a live lock bit that rises only after a run of consecutive in-range samples, so the bit does not chatter.

Lock losses fall into two classes:
- **Expected losses** come from software changing the multiplier, the clock select, or (in the FLL-engaged internal mode only) the trim. These drop the live lock bit and nothing else.
- **Unexpected losses** also set a sticky loss-of-lock flag. The causes are:
  - the raw indication falling while locked;
  - a loss-of-clock event in either FLL-engaged mode;
  - clocks stopping during stop mode while the loop was locked. In this case the flag is set at wake-up.

The sticky flag raises a reset request or an interrupt request, depending on a reset-enable input. Software clears the flag with a status read followed by a write of 1 to the flag bit.

Top module: `fll_lock_tracker`

## Requirements
- R1: After reset, lock_o, lol_flag_o, irq_o and rst_req_o are all 0.
- R2: lock_o goes to 1 only after LOCK_CNT consecutive cycles with raw_lock_i = 1 and no drop cause. A cycle with raw_lock_i = 0 clears lock_o after that edge and restarts the count.
- R3: A pulse on mult_chg_i or csel_chg_i clears lock_o after that edge and leaves lol_flag_o unchanged.
- R4: A pulse on trim_chg_i clears lock_o only when mode_i is the FLL-engaged internal mode (code 3'd2). In any other mode it changes neither lock_o nor lol_flag_o. The other mode codes are: off 3'd0, self-clocked 3'd1, bypassed external 3'd3, FLL-engaged external 3'd4.
- R5: A pulse on loc_evt_i while mode_i is 3'd2 or 3'd4 clears lock_o and sets lol_flag_o. In any other mode it changes neither.
- R6: Outside stop, raw_lock_i = 0 while lock_o = 1 sets lol_flag_o, unless a multiplier, clock-select or qualifying trim change arrives in the same cycle.
- R7: A stop_clk_lost_i pulse while stop_i = 1 and lock_o = 1 clears lock_o. It leaves lol_flag_o at 0 for the rest of stop, and sets lol_flag_o on the edge that first samples stop_i = 0.
- R8: flag_clr_wr_i clears lol_flag_o only if stat_rd_i was seen earlier and no write has happened since. A write without such a read leaves the flag set. A set cause in the same cycle as a valid clear wins.
- R9: With lol_rst_en_i = 0, irq_o equals lol_flag_o and rst_req_o is 0.
- R10: With lol_rst_en_i = 1, rst_req_o equals lol_flag_o and irq_o is held at 0, so the reset overrides the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raw_lock_i | input | 1 | Raw lock indication from the comparator |
| mult_chg_i | input | 1 | Multiplier field written (pulse) |
| csel_chg_i | input | 1 | Clock-select field written (pulse) |
| trim_chg_i | input | 1 | Trim field written (pulse) |
| mode_i | input | 3 | Current operating mode code |
| stop_i | input | 1 | Chip is in stop mode |
| stop_clk_lost_i | input | 1 | Clocks stopped unexpectedly during stop (pulse) |
| loc_evt_i | input | 1 | Loss-of-clock event (pulse) |
| stat_rd_i | input | 1 | Status register read (pulse) |
| flag_clr_wr_i | input | 1 | Write of 1 to the flag bit (pulse) |
| lol_rst_en_i | input | 1 | 1: flag requests reset; 0: flag requests interrupt |
| lock_o | output | 1 | Filtered live lock bit |
| lol_flag_o | output | 1 | Sticky unexpected loss-of-lock flag |
| irq_o | output | 1 | Interrupt request |
| rst_req_o | output | 1 | Reset request |

## Verification
Timing of each result after its stimulus:
- Every drop and set cause acts on the edge that samples it, so lock_o and lol_flag_o are due one edge after the stimulus.
- The clear write likewise acts one edge after it is sampled.
- A wake-up sets the flag on the first edge that samples stop_i low.
- A rising lock_o is due only on the LOCK_CNT-th consecutive sampling edge.
- irq_o and rst_req_o follow the flag register and the enable input combinationally, in the same cycle.

The bench drives each input on a falling edge and compares on the next falling edge, which is exactly one sampling edge later. For lock recovery it counts the sampling edges explicitly, so it expects 0 until the third sample of its LOCK_CNT = 3 build.

// File: rtl/fll_lock_pkg.sv
`timescale 1ns/1ps
package fll_lock_pkg;

   typedef enum logic [2:0] {
      MODE_OFF     = 3'd0,
      MODE_SELF    = 3'd1,
      MODE_FLL_INT = 3'd2,
      MODE_BYP_EXT = 3'd3,
      MODE_FLL_EXT = 3'd4
   } clk_mode_e;

   function automatic logic fll_engaged(input clk_mode_e m);
      return (m == MODE_FLL_INT) || (m == MODE_FLL_EXT);
   endfunction

endpackage

// File: rtl/lock_debounce.sv
`timescale 1ns/1ps
module lock_debounce #(
   parameter int LOCK_CNT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   input  logic drop_i,
   output logic lock_o
);

   logic lock_q;

   initial begin
      assert (LOCK_CNT >= 1) else $error("LOCK_CNT must be at least 1");
   end

   generate
      if (LOCK_CNT == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lock_q <= 1'b0;
            else        lock_q <= raw_i & ~drop_i;
         end
      end else begin : g_count
         localparam int CW = $clog2(LOCK_CNT);
         localparam logic [CW-1:0] LAST = CW'(LOCK_CNT - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q  <= '0;
               lock_q <= 1'b0;
            end else if (!raw_i || drop_i) begin
               cnt_q  <= '0;
               lock_q <= 1'b0;
            end else if (!lock_q) begin
               if (cnt_q == LAST) lock_q <= 1'b1;
               else               cnt_q  <= cnt_q + 1'b1;
            end
         end
      end
   endgenerate

   assign lock_o = lock_q;

   // R2: a rising lock needs a clean sample in the cycle before
   a_r2_rise_needs_raw: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_q) |-> ($past(raw_i) && !$past(drop_i)));

   // R2: any low sample or drop cause clears lock at the next edge
   a_r2_low_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (!raw_i || drop_i) |=> !lock_q);

endmodule

// File: rtl/lol_classifier.sv
`timescale 1ns/1ps
module lol_classifier
   import fll_lock_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  clk_mode_e mode_i,
   input  logic      lock_i,
   input  logic      raw_i,
   input  logic      mult_chg_i,
   input  logic      csel_chg_i,
   input  logic      trim_chg_i,
   input  logic      loc_evt_i,
   input  logic      stop_i,
   input  logic      stop_clk_lost_i,
   output logic      drop_o,
   output logic      set_o
);

   logic expected_loss;
   logic loc_loss;
   logic raw_loss;
   logic stop_loss;
   logic wake;
   logic stop_q;
   logic pend_q;

   assign expected_loss = mult_chg_i | csel_chg_i |
                          (trim_chg_i & (mode_i == MODE_FLL_INT));
   assign loc_loss      = loc_evt_i & fll_engaged(mode_i);
   assign raw_loss      = ~stop_i & lock_i & ~raw_i & ~expected_loss;
   assign stop_loss     = stop_i & stop_clk_lost_i;
   assign wake          = stop_q & ~stop_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stop_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         stop_q <= stop_i;
         if (stop_loss && lock_i) pend_q <= 1'b1;
         else if (wake)           pend_q <= 1'b0;
      end
   end

   assign drop_o = expected_loss | loc_loss | stop_loss;
   assign set_o  = loc_loss | raw_loss | (wake & pend_q);

   // R7: no flag set cause from the stop path while still stopped
   a_r7_quiet_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !loc_loss && !raw_loss) |-> !set_o);

   // R4: a trim change outside the internal FLL mode is no drop cause
   a_r4_trim_other_modes: assert property (@(posedge clk) disable iff (!rst_n)
      (trim_chg_i && !mult_chg_i && !csel_chg_i && !loc_evt_i && !stop_i &&
       mode_i != MODE_FLL_INT) |-> !drop_o);

endmodule

// File: rtl/lol_flag.sv
`timescale 1ns/1ps
module lol_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic rd_i,
   input  logic clr_wr_i,
   input  logic rst_en_i,
   output logic flag_o,
   output logic irq_o,
   output logic rst_req_o
);

   logic flag_q;
   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q  <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         if (set_i)                    flag_q <= 1'b1;
         else if (clr_wr_i && armed_q) flag_q <= 1'b0;
         if (rd_i)          armed_q <= 1'b1;
         else if (clr_wr_i) armed_q <= 1'b0;
      end
   end

   assign flag_o    = flag_q;
   assign irq_o     = flag_q & ~rst_en_i;
   assign rst_req_o = flag_q &  rst_en_i;

   // R8: the flag only falls after an armed clear write with no set
   a_r8_clear_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q) |-> $past(clr_wr_i && armed_q && !set_i));

   // R8: a set cause always leaves the flag high
   a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_q);

   // R10: reset request and interrupt request never coexist
   a_r10_reset_overrides: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_o && rst_req_o));

endmodule

// File: rtl/fll_lock_tracker.sv
`timescale 1ns/1ps
module fll_lock_tracker
   import fll_lock_pkg::*;
#(
   parameter int LOCK_CNT = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       raw_lock_i,
   input  logic       mult_chg_i,
   input  logic       csel_chg_i,
   input  logic       trim_chg_i,
   input  logic [2:0] mode_i,
   input  logic       stop_i,
   input  logic       stop_clk_lost_i,
   input  logic       loc_evt_i,
   input  logic       stat_rd_i,
   input  logic       flag_clr_wr_i,
   input  logic       lol_rst_en_i,
   output logic       lock_o,
   output logic       lol_flag_o,
   output logic       irq_o,
   output logic       rst_req_o
);

   clk_mode_e mode;
   logic      drop;
   logic      set_evt;

   assign mode = clk_mode_e'(mode_i);

   lock_debounce #(.LOCK_CNT(LOCK_CNT)) u_debounce (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (raw_lock_i),
      .drop_i (drop),
      .lock_o (lock_o)
   );

   lol_classifier u_classify (
      .clk             (clk),
      .rst_n           (rst_n),
      .mode_i          (mode),
      .lock_i          (lock_o),
      .raw_i           (raw_lock_i),
      .mult_chg_i      (mult_chg_i),
      .csel_chg_i      (csel_chg_i),
      .trim_chg_i      (trim_chg_i),
      .loc_evt_i       (loc_evt_i),
      .stop_i          (stop_i),
      .stop_clk_lost_i (stop_clk_lost_i),
      .drop_o          (drop),
      .set_o           (set_evt)
   );

   lol_flag u_flag (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (set_evt),
      .rd_i      (stat_rd_i),
      .clr_wr_i  (flag_clr_wr_i),
      .rst_en_i  (lol_rst_en_i),
      .flag_o    (lol_flag_o),
      .irq_o     (irq_o),
      .rst_req_o (rst_req_o)
   );

   // R3: multiplier or clock-select change drops the live lock bit
   a_r3_cfg_drops_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (mult_chg_i || csel_chg_i) |=> !lock_o);

   // R5: loss of clock in an FLL-engaged mode raises the sticky flag
   a_r5_loc_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_evt_i && (mode_i == 3'd2 || mode_i == 3'd4)) |=> (lol_flag_o && !lock_o));

   // R9: with the reset enable low no reset is requested
   a_r9_irq_path: assert property (@(posedge clk) disable iff (!rst_n)
      !lol_rst_en_i |-> !rst_req_o);

endmodule

// File: tb/test_fll_lock_tracker.sv
`timescale 1ns/1ps
module test_fll_lock_tracker;

   localparam int LCNT = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic raw = 0, mult = 0, csel = 0, trim = 0, stp = 0, lost = 0, loc = 0;
   logic rd = 0, wr = 0, rsten = 0;
   logic [2:0] mode = 3'd0;
   logic lock, flag, irq, rreq;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   fll_lock_tracker #(.LOCK_CNT(LCNT)) i_fll_lock_tracker (
      .clk(clk), .rst_n(rst_n), .raw_lock_i(raw), .mult_chg_i(mult),
      .csel_chg_i(csel), .trim_chg_i(trim), .mode_i(mode), .stop_i(stp),
      .stop_clk_lost_i(lost), .loc_evt_i(loc), .stat_rd_i(rd),
      .flag_clr_wr_i(wr), .lol_rst_en_i(rsten), .lock_o(lock),
      .lol_flag_o(flag), .irq_o(irq), .rst_req_o(rreq)
   );

   typedef struct packed {
      logic       raw, mult, csel, trim, loc;
      logic [2:0] mode;
      logic       lk, fl;
   } vec_t;

   localparam int NV = 22;
   localparam vec_t VEC [NV] = '{
      '{1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0},  // R2 sample 1
      '{1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0},  // R2 sample 2
      '{1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,1'b1,1'b0},  // R2 locked
      '{1'b1,1'b1,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0},  // R3 multiplier
      '{1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0},
      '{1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0},
      '{1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,1'b1,1'b0},
      '{1'b1,1'b0,1'b1,1'b0,1'b0,3'd0,1'b0,1'b0},  // R3 clock select
      '{1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0},
      '{1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0},
      '{1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,1'b1,1'b0},
      '{1'b1,1'b0,1'b0,1'b1,1'b0,3'd1,1'b1,1'b0},  // R4 trim, self mode
      '{1'b1,1'b0,1'b0,1'b1,1'b0,3'd2,1'b0,1'b0},  // R4 trim, FLL int
      '{1'b1,1'b0,1'b0,1'b0,1'b0,3'd2,1'b0,1'b0},
      '{1'b1,1'b0,1'b0,1'b0,1'b0,3'd2,1'b0,1'b0},
      '{1'b1,1'b0,1'b0,1'b0,1'b0,3'd2,1'b1,1'b0},
      '{1'b1,1'b0,1'b0,1'b0,1'b1,3'd3,1'b1,1'b0},  // R5 loc, bypass
      '{1'b1,1'b0,1'b0,1'b0,1'b1,3'd0,1'b1,1'b0},  // R5 loc, off
      '{1'b1,1'b0,1'b0,1'b0,1'b1,3'd4,1'b0,1'b1},  // R5 loc, FLL ext
      '{1'b1,1'b0,1'b0,1'b0,1'b0,3'd4,1'b0,1'b1},
      '{1'b1,1'b0,1'b0,1'b0,1'b0,3'd4,1'b0,1'b1},
      '{1'b1,1'b0,1'b0,1'b0,1'b0,3'd4,1'b1,1'b1}
   };

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      mult = 0; csel = 0; trim = 0; loc = 0; lost = 0; rd = 0; wr = 0;
   endtask

   task automatic relock();
      raw = 1;
      for (int k = 0; k < LCNT; k++) step();
   endtask

   initial begin
      #400000;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 lock", lock, 1'b0);
      chk("R1 flag", flag, 1'b0);
      chk("R1 irq", irq, 1'b0);
      chk("R1 rstreq", rreq, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         raw = VEC[i].raw; mult = VEC[i].mult; csel = VEC[i].csel;
         trim = VEC[i].trim; loc = VEC[i].loc; mode = VEC[i].mode;
         step();
         chk($sformatf("R2-R5 vec%0d lock", i), lock, VEC[i].lk);
         chk($sformatf("R2-R5 vec%0d flag", i), flag, VEC[i].fl);
      end
      // flag is set, lock is held, interrupt path selected
      chk("R9 irq", irq, 1'b1);
      chk("R9 rstreq", rreq, 1'b0);

      wr = 1; step();
      chk("R8 unarmed write", flag, 1'b1);
      rd = 1; step();
      chk("R8 after read", flag, 1'b1);
      wr = 1; step();
      chk("R8 armed clear", flag, 1'b0);
      chk("R9 irq cleared", irq, 1'b0);

      mode = 3'd0; raw = 0; step();
      chk("R6 raw drop lock", lock, 1'b0);
      chk("R6 raw drop flag", flag, 1'b1);

      rsten = 1; step();
      chk("R10 rstreq", rreq, 1'b1);
      chk("R10 irq masked", irq, 1'b0);
      rd = 1; step();
      wr = 1; step();
      chk("R10 cleared", rreq, 1'b0);
      rsten = 0;

      rd = 1; step();
      wr = 1; loc = 1; mode = 3'd4; step();
      chk("R8 set wins", flag, 1'b1);
      rd = 1; step();
      wr = 1; step();
      chk("R8 clear again", flag, 1'b0);

      mode = 3'd0;
      relock();
      chk("R7 locked before stop", lock, 1'b1);
      stp = 1; step();
      lost = 1; step();
      chk("R7 lock dropped", lock, 1'b0);
      chk("R7 no flag in stop", flag, 1'b0);
      step();
      chk("R7 still quiet", flag, 1'b0);
      stp = 0; step();
      chk("R7 flag at wake", flag, 1'b1);

      rst_n = 0; @(negedge clk);
      chk("R1 reset flag", flag, 1'b0);
      chk("R1 reset lock", lock, 1'b0);
      rst_n = 1; @(negedge clk);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule